// File: doc/BRIEF.md
# Input Enable Sample Qualifier

This block sits in front of one filter channel of a wideband receiver. Two ADC input ports, A and B, each deliver a two's complement mantissa, an unsigned exponent and an enable line. A control bit picks one port. The enable line of that port is then read in one of four modes, and the block decides on each clock what sample the channel receives and whether the oscillator phase steps.

The four modes cover two uses. Blanking zeroes the data while the oscillator keeps running, which suits time-division streams. Gated capture takes a sample on every enabled clock and freezes the oscillator otherwise. The two edge modes take exactly one sample on the first clock after a rising or a falling enable edge. Edge capture lets one channel follow each half of an interleaved diversity stream, or run the clock faster than the data rate. The downstream filters are strobed on every clock in all modes. A separate field routes one of four external sync pins to the channel.

Top module: `adc_enable_qualifier`

## Requirements
- R1: While rst_ni is low, mant_o, exp_o, capture_o, nco_step_o and proc_en_o are all zero.
- R2: All outputs except sync_o are registered. The outputs after clock edge k reflect the inputs sampled at edge k. In mode 2'b00 with the selected enable high, the selected mantissa and exponent appear on mant_o and exp_o, and capture_o and nco_step_o are 1.
- R3: In mode 2'b00 with the selected enable low, mant_o and exp_o become zero, capture_o is 0 and nco_step_o is still 1.
- R4: In mode 2'b01 with the selected enable high, the selected sample is loaded on every clock, and capture_o and nco_step_o are 1.
- R5: In mode 2'b01 with the selected enable low, no sample is loaded, and capture_o and nco_step_o are 0.
- R6: In mode 2'b10, a sample is loaded and capture_o is 1 only on an edge where the enable is high and was low at the previous edge. The previous value is 0 after reset.
- R7: In mode 2'b11, a sample is loaded and capture_o is 1 only on an edge where the enable is low and was high at the previous edge.
- R8: In modes 2'b10 and 2'b11, nco_step_o equals capture_o, so the phase steps once per captured sample.
- R9: In modes 2'b01, 2'b10 and 2'b11, mant_o and exp_o keep the last captured sample between captures.
- R10: When port_sel_i is 1, the B port's mantissa, exponent and enable are used. When it is 0, the A port's are used. The enable of the unselected port has no effect.
- R11: sync_o follows sync_i[sync_sel_i] without delay. Codes 00, 01, 10 and 11 select sync_i bits 0, 1, 2 and 3.
- R12: proc_en_o is 1 after every clock edge that follows reset release, in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_sel_i | input | 1 | 0 picks port A, 1 picks port B |
| mode_i | input | 2 | Enable interpretation mode |
| sync_sel_i | input | 2 | Sync pin select |
| a_mant_i | input | MANT_W | Port A mantissa, two's complement |
| a_exp_i | input | EXP_W | Port A exponent, unsigned |
| a_en_i | input | 1 | Port A enable |
| b_mant_i | input | MANT_W | Port B mantissa, two's complement |
| b_exp_i | input | EXP_W | Port B exponent, unsigned |
| b_en_i | input | 1 | Port B enable |
| sync_i | input | NUM_SYNC | External sync pins |
| mant_o | output | MANT_W | Qualified mantissa |
| exp_o | output | EXP_W | Qualified exponent |
| capture_o | output | 1 | A new real sample was taken |
| nco_step_o | output | 1 | Advance the oscillator phase |
| proc_en_o | output | 1 | Downstream filter clock enable |
| sync_o | output | 1 | Selected sync pin |

## Verification
The bench builds the block with its default widths: a 14-bit mantissa, a 3-bit exponent and four sync pins. With these widths the bench can drive full-scale negative mantissas and every exponent code. It can also walk all four sync codes with a one-hot and an inverted one-hot pattern. The edge modes are run through level runs, both edge directions and mode changes that carry the remembered enable across. This shows that a long high or low level never produces a second capture.

// File: rtl/qual_pkg.sv
package qual_pkg;
  typedef enum logic [1:0] {
    MODE_BLANK = 2'b00,
    MODE_GATED = 2'b01,
    MODE_RISE  = 2'b10,
    MODE_FALL  = 2'b11
  } qual_mode_e;
endpackage

// File: rtl/qual_port_mux.sv
module qual_port_mux #(
  parameter int MANT_W = 14,
  parameter int EXP_W  = 3
) (
  input  logic              sel_i,
  input  logic [MANT_W-1:0] a_mant_i,
  input  logic [EXP_W-1:0]  a_exp_i,
  input  logic              a_en_i,
  input  logic [MANT_W-1:0] b_mant_i,
  input  logic [EXP_W-1:0]  b_exp_i,
  input  logic              b_en_i,
  output logic [MANT_W-1:0] mant_o,
  output logic [EXP_W-1:0]  exp_o,
  output logic              en_o
);
  always_comb begin
    if (sel_i) begin
      mant_o = b_mant_i;
      exp_o  = b_exp_i;
      en_o   = b_en_i;
    end else begin
      mant_o = a_mant_i;
      exp_o  = a_exp_i;
      en_o   = a_en_i;
    end
  end
endmodule

// File: rtl/qual_enable_decoder.sv
module qual_enable_decoder
  import qual_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       en_i,
  output logic       load_o,
  output logic       blank_o,
  output logic       fresh_o,
  output logic       step_o
);
  logic       en_q;
  qual_mode_e mode;

  assign mode = qual_mode_e'(mode_i);

  // previous enable tracked in every mode so a mode change sees true history
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= en_i;
  end

  always_comb begin
    load_o  = 1'b0;
    blank_o = 1'b0;
    fresh_o = 1'b0;
    step_o  = 1'b0;
    unique case (mode)
      MODE_BLANK: begin
        load_o  = 1'b1;
        blank_o = !en_i;
        fresh_o = en_i;
        step_o  = 1'b1;
      end
      MODE_GATED: begin
        load_o  = en_i;
        fresh_o = en_i;
        step_o  = en_i;
      end
      MODE_RISE: begin
        load_o  = en_i && !en_q;
        fresh_o = en_i && !en_q;
        step_o  = en_i && !en_q;
      end
      MODE_FALL: begin
        load_o  = !en_i && en_q;
        fresh_o = !en_i && en_q;
        step_o  = !en_i && en_q;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/qual_sample_reg.sv
module qual_sample_reg #(
  parameter int MANT_W = 14,
  parameter int EXP_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              blank_i,
  input  logic              fresh_i,
  input  logic              step_i,
  input  logic [MANT_W-1:0] mant_i,
  input  logic [EXP_W-1:0]  exp_i,
  output logic [MANT_W-1:0] mant_o,
  output logic [EXP_W-1:0]  exp_o,
  output logic              capture_o,
  output logic              nco_step_o,
  output logic              proc_en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mant_o     <= '0;
      exp_o      <= '0;
      capture_o  <= 1'b0;
      nco_step_o <= 1'b0;
      proc_en_o  <= 1'b0;
    end else begin
      if (load_i) begin
        mant_o <= blank_i ? '0 : mant_i;
        exp_o  <= blank_i ? '0 : exp_i;
      end
      capture_o  <= fresh_i;
      nco_step_o <= step_i;
      proc_en_o  <= 1'b1;
    end
  end
endmodule

// File: rtl/adc_enable_qualifier.sv
module adc_enable_qualifier #(
  parameter int MANT_W   = 14,
  parameter int EXP_W    = 3,
  parameter int NUM_SYNC = 4,
  localparam int SYNC_SEL_W = (NUM_SYNC > 1) ? $clog2(NUM_SYNC) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  port_sel_i,
  input  logic [1:0]            mode_i,
  input  logic [SYNC_SEL_W-1:0] sync_sel_i,
  input  logic [MANT_W-1:0]     a_mant_i,
  input  logic [EXP_W-1:0]      a_exp_i,
  input  logic                  a_en_i,
  input  logic [MANT_W-1:0]     b_mant_i,
  input  logic [EXP_W-1:0]      b_exp_i,
  input  logic                  b_en_i,
  input  logic [NUM_SYNC-1:0]   sync_i,
  output logic [MANT_W-1:0]     mant_o,
  output logic [EXP_W-1:0]      exp_o,
  output logic                  capture_o,
  output logic                  nco_step_o,
  output logic                  proc_en_o,
  output logic                  sync_o
);
  logic [MANT_W-1:0] sel_mant;
  logic [EXP_W-1:0]  sel_exp;
  logic              sel_en;
  logic              load, blank, fresh, step;

  qual_port_mux #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_mux (
    .sel_i   (port_sel_i),
    .a_mant_i(a_mant_i), .a_exp_i(a_exp_i), .a_en_i(a_en_i),
    .b_mant_i(b_mant_i), .b_exp_i(b_exp_i), .b_en_i(b_en_i),
    .mant_o  (sel_mant), .exp_o(sel_exp), .en_o(sel_en)
  );

  qual_enable_decoder u_dec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode_i),
    .en_i   (sel_en),
    .load_o (load),
    .blank_o(blank),
    .fresh_o(fresh),
    .step_o (step)
  );

  qual_sample_reg #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .blank_i   (blank),
    .fresh_i   (fresh),
    .step_i    (step),
    .mant_i    (sel_mant),
    .exp_i     (sel_exp),
    .mant_o    (mant_o),
    .exp_o     (exp_o),
    .capture_o (capture_o),
    .nco_step_o(nco_step_o),
    .proc_en_o (proc_en_o)
  );

  assign sync_o = sync_i[sync_sel_i];
endmodule

// File: rtl/adc_enable_qualifier_chk.sv
module adc_enable_qualifier_chk #(
  parameter int MANT_W   = 14,
  parameter int EXP_W    = 3,
  parameter int NUM_SYNC = 4,
  localparam int SYNC_SEL_W = (NUM_SYNC > 1) ? $clog2(NUM_SYNC) : 1
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  port_sel_i,
  input logic [1:0]            mode_i,
  input logic                  a_en_i,
  input logic                  b_en_i,
  input logic [MANT_W-1:0]     mant_o,
  input logic [EXP_W-1:0]      exp_o,
  input logic                  capture_o,
  input logic                  nco_step_o,
  input logic                  proc_en_o
);
  logic en_sel, en_hist;
  assign en_sel = port_sel_i ? b_en_i : a_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_hist <= 1'b0;
    else         en_hist <= en_sel;
  end

  p_blank_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00 && !en_sel) |=> (mant_o == '0 && exp_o == '0 && nco_step_o && !capture_o));

  p_gated_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b01 && !en_sel) |=> ($stable(mant_o) && $stable(exp_o) && !nco_step_o));

  p_rise_capture_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b10 && en_sel && !en_hist) |=> capture_o);

  p_fall_capture_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b11 && !(!en_sel && en_hist)) |=> !capture_o);

  p_step_once_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i[1] |=> (nco_step_o == capture_o));

  p_proc_run_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> proc_en_o);
endmodule

bind adc_enable_qualifier adc_enable_qualifier_chk #(
  .MANT_W(MANT_W), .EXP_W(EXP_W), .NUM_SYNC(NUM_SYNC)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .port_sel_i(port_sel_i), .mode_i(mode_i),
  .a_en_i(a_en_i), .b_en_i(b_en_i), .mant_o(mant_o), .exp_o(exp_o),
  .capture_o(capture_o), .nco_step_o(nco_step_o), .proc_en_o(proc_en_o)
);

// File: tb/adc_enable_qualifier_tb_top.sv
module adc_enable_qualifier_tb_top;
  localparam int MANT_W = 14;
  localparam int EXP_W  = 3;
  localparam int NSYNC  = 4;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              port_sel_i = 1'b0;
  logic [1:0]        mode_i = 2'b00;
  logic [1:0]        sync_sel_i = 2'b00;
  logic [MANT_W-1:0] a_mant_i = '0, b_mant_i = '0;
  logic [EXP_W-1:0]  a_exp_i = '0, b_exp_i = '0;
  logic              a_en_i = 1'b0, b_en_i = 1'b0;
  logic [NSYNC-1:0]  sync_i = '0;
  logic [MANT_W-1:0] mant_o;
  logic [EXP_W-1:0]  exp_o;
  logic              capture_o, nco_step_o, proc_en_o, sync_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk_i = ~clk_i;

  adc_enable_qualifier #(.MANT_W(MANT_W), .EXP_W(EXP_W), .NUM_SYNC(NSYNC)) dut_i (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // one clock: inputs set at negedge, outputs sampled at next negedge
  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
    chk("R12 proc_en", proc_en_o, 1);
  endtask

  task automatic expect_out(input string tag, input int m, input int e, input int cap, input int stp);
    chk({tag, " mant"}, mant_o, m);
    chk({tag, " exp"}, exp_o, e);
    chk({tag, " capture"}, capture_o, cap);
    chk({tag, " step"}, nco_step_o, stp);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    a_en_i = 1'b1; a_mant_i = 14'h1555; a_exp_i = 3'd4;
    repeat (3) @(negedge clk_i);
    expect_out("R1 reset", 0, 0, 0, 0);
    chk("R1 proc_en", proc_en_o, 0);
    a_en_i = 1'b0; a_mant_i = '0; a_exp_i = '0;
    rst_ni = 1'b1;
  endtask

  task automatic t_blank();
    mode_i = 2'b00; port_sel_i = 1'b0;
    a_en_i = 1'b1; a_mant_i = 14'h1234; a_exp_i = 3'd5; tick();
    expect_out("R2 blank pass", 'h1234, 5, 1, 1);
    a_en_i = 1'b0; a_mant_i = 14'h0abc; a_exp_i = 3'd3; tick();
    expect_out("R3 blank zero", 0, 0, 0, 1);
    a_mant_i = 14'h2001; tick();
    expect_out("R3 blank zero again", 0, 0, 0, 1);
  endtask

  task automatic t_gated();
    mode_i = 2'b01;
    a_en_i = 1'b1; a_mant_i = 14'h3fff; a_exp_i = 3'd7; tick();
    expect_out("R4 gated pass", 'h3fff, 7, 1, 1);
    a_mant_i = 14'h2000; a_exp_i = 3'd6; tick();
    expect_out("R4 gated next", 'h2000, 6, 1, 1);
    a_en_i = 1'b0; a_mant_i = 14'h0001; a_exp_i = 3'd0; tick();
    expect_out("R5 R9 gated hold", 'h2000, 6, 0, 0);
  endtask

  task automatic t_rise();
    mode_i = 2'b10;
    a_en_i = 1'b0; a_mant_i = 14'h0011; tick();
    expect_out("R6 rise low", 'h2000, 6, 0, 0);
    a_en_i = 1'b1; a_mant_i = 14'h0101; a_exp_i = 3'd1; tick();
    expect_out("R6 R8 rise edge", 'h0101, 1, 1, 1);
    a_mant_i = 14'h0202; a_exp_i = 3'd2; tick();
    expect_out("R6 R9 rise level", 'h0101, 1, 0, 0);
    a_en_i = 1'b0; a_mant_i = 14'h0303; tick();
    expect_out("R6 rise fall ignored", 'h0101, 1, 0, 0);
    a_en_i = 1'b1; a_mant_i = 14'h0404; a_exp_i = 3'd4; tick();
    expect_out("R6 rise second", 'h0404, 4, 1, 1);
  endtask

  task automatic t_fall();
    mode_i = 2'b11;
    a_mant_i = 14'h0505; tick();
    expect_out("R7 fall high", 'h0404, 4, 0, 0);
    a_en_i = 1'b0; a_mant_i = 14'h2606; a_exp_i = 3'd2; tick();
    expect_out("R7 R8 fall edge", 'h2606, 2, 1, 1);
    a_mant_i = 14'h0707; a_exp_i = 3'd3; tick();
    expect_out("R7 R9 fall level", 'h2606, 2, 0, 0);
    a_en_i = 1'b1; tick();
    expect_out("R7 fall rise ignored", 'h2606, 2, 0, 0);
  endtask

  task automatic t_port();
    mode_i = 2'b01; port_sel_i = 1'b1;
    a_en_i = 1'b0; a_mant_i = 14'h2222; a_exp_i = 3'd1;
    b_en_i = 1'b1; b_mant_i = 14'h1111; b_exp_i = 3'd4; tick();
    expect_out("R10 port B", 'h1111, 4, 1, 1);
    a_en_i = 1'b1; a_mant_i = 14'h3333; a_exp_i = 3'd6; b_en_i = 1'b0; tick();
    expect_out("R10 A enable ignored", 'h1111, 4, 0, 0);
    port_sel_i = 1'b0; tick();
    expect_out("R10 port A", 'h3333, 6, 1, 1);
  endtask

  task automatic t_sync();
    for (int i = 0; i < NSYNC; i++) begin
      sync_sel_i = 2'(i);
      sync_i = 4'b0001 << i;
      #1 chk("R11 sync one-hot", sync_o, 1);
      sync_i = ~(4'b0001 << i);
      #1 chk("R11 sync inverted", sync_o, 0);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    t_reset();
    t_blank();
    t_gated();
    t_rise();
    t_fall();
    t_port();
    t_sync();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule